// File: doc/BRIEF.md
# Inverter Leg Pulse Conditioner

This block sits between a phase's modulator and the gate drivers of one inverter leg. It takes the raw PWM bit for that phase. A minimum-width filter deletes every high or low excursion that is shorter than a programmed number of carrier ticks. The filtered level is then split into a top-switch drive and a bottom-switch drive that are complementary in intent. Every turn-on edge is held back by a programmed underlap, so both switches sit off through each change of state.

Both lengths are set by inverted binary codes and are counted in carrier ticks. A tick is a one-cycle enable that the carrier generator supplies. An active-low inhibit and a force-off input (driven by trip or system reset) clamp both drives low after the two timing stages. The stages keep running underneath the clamp.

Top module: `phase_gate_conditioner`

## Requirements
- R1: While `rst_n` is low both drives are low and the filtered level is low. After release with `pwm_raw` low, `drv_lo` rises on the clock edge on which the pdy-th tick is counted, and `drv_hi` stays low.
- R2: The minimum width pdt equals 128 minus the unsigned value of `del_code`, giving 1 to 128 ticks (code 127 gives 1, code 0 gives 128). The underlap pdy equals 64 minus the unsigned value of `dly_code`, giving 1 to 64 ticks.
- R3: A high excursion of `pwm_raw` that lasts at least pdt ticks reaches the drive stage with its length unchanged. One that lasts fewer ticks is removed completely. A return of the input to the filtered level restarts the count.
- R4: A low excursion follows the same rule as R3, with the polarity reversed.
- R5: A rise of `drv_hi` or `drv_lo` comes pdy ticks after the filtered level changes. A fall comes in the same cycle as that change, and the two drives are never high together. With a tick on every cycle, a passed high pulse of len ticks gives `drv_hi` high for len−pdy cycles and `drv_lo` low for len+pdy cycles. The first `drv_hi` high cycle comes pdt+pdy cycles after the first clock edge that sees the input high, counting that edge as the first.
- R6: Filter and underlap counters advance only in cycles where `tick_en` is 1.
- R7: `inh_n` = 0 forces both drives low in the same cycle. Filtering and underlap timing continue underneath, so on release the drives show the current settled state at once.
- R8: `force_off` = 1 forces both drives low in the same cycle, whatever the other inputs are.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle carrier tick enable |
| pwm_raw | input | 1 | Unfiltered PWM level for this phase |
| del_code | input | DEL_W (7) | Minimum-width code, pdt = 128 − code |
| dly_code | input | DLY_W (6) | Underlap code, pdy = 64 − code |
| inh_n | input | 1 | Output inhibit, active low |
| force_off | input | 1 | Trip or reset clamp, active high |
| drv_hi | output | 1 | Top switch drive |
| drv_lo | output | 1 | Bottom switch drive |

## Verification
The properties assume that `pwm_raw` and `tick_en` change only between clock edges. They also assume that the timing codes are quasi-static: a code may change, but not while a pulse being measured is in flight. The stimulus moves every input a quarter period after a rising edge. It loads new codes only while the input has rested longer than the largest pdt plus pdy, so every measured pulse sees one set of lengths from start to finish.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef enum logic [1:0] {
    DRV_OFF = 2'b00,
    DRV_TOP = 2'b01,
    DRV_BOT = 2'b10
  } drive_e;
endpackage

// File: rtl/min_width_filter.sv
module min_width_filter #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              din,
  input  logic [CODE_W-1:0] code,
  output logic              dout
);
  localparam int MAXLEN = 1 << CODE_W;
  localparam int CW     = $clog2(MAXLEN) + 1;

  logic          lvl_q, lvl_d;
  logic [CW-1:0] run_q, run_d;
  logic [CW-1:0] need;
  logic [CW-1:0] run_inc;

  // inverted code: all ones is the shortest length
  assign need    = CW'(MAXLEN) - {{(CW-CODE_W){1'b0}}, code};
  assign run_inc = (run_q == CW'(MAXLEN)) ? run_q : run_q + CW'(1);

  always_comb begin
    lvl_d = lvl_q;
    run_d = run_q;
    if (din == lvl_q) begin
      run_d = '0;
    end else if (tick_en) begin
      if (run_inc >= need) begin
        lvl_d = din;
        run_d = '0;
      end else begin
        run_d = run_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      run_q <= run_d;
    end
  end

  assign dout = lvl_q;
endmodule

// File: rtl/underlap_split.sv
module underlap_split
  import pgc_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              din,
  input  logic [CODE_W-1:0] code,
  output drive_e            state
);
  localparam int MAXLEN = 1 << CODE_W;
  localparam int CW     = $clog2(MAXLEN) + 1;

  logic          lvl_q, lvl_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] need;
  logic          settled;

  assign need = CW'(MAXLEN) - {{(CW-CODE_W){1'b0}}, code};

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (din != lvl_q) begin
      lvl_d = din;
      cnt_d = tick_en ? CW'(1) : '0;
    end else if (tick_en && (cnt_q != CW'(MAXLEN))) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  // a fresh input change drops both drives in the same cycle
  assign settled = (din == lvl_q) && (cnt_q >= need);

  always_comb begin
    if (!settled)   state = DRV_OFF;
    else if (lvl_q) state = DRV_TOP;
    else            state = DRV_BOT;
  end
endmodule

// File: rtl/drive_gate.sv
module drive_gate
  import pgc_pkg::*;
(
  input  drive_e state,
  input  logic   inh_n,
  input  logic   force_off,
  output logic   drv_hi,
  output logic   drv_lo
);
  logic pass;

  assign pass   = inh_n && !force_off;
  assign drv_hi = pass && (state == DRV_TOP);
  assign drv_lo = pass && (state == DRV_BOT);
endmodule

// File: rtl/phase_gate_conditioner.sv
module phase_gate_conditioner
  import pgc_pkg::*;
#(
  parameter int DEL_W = 7,
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             pwm_raw,
  input  logic [DEL_W-1:0] del_code,
  input  logic [DLY_W-1:0] dly_code,
  input  logic             inh_n,
  input  logic             force_off,
  output logic             drv_hi,
  output logic             drv_lo
);
  logic   filt_lvl;
  drive_e leg_state;

  min_width_filter #(.CODE_W(DEL_W)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .din     (pwm_raw),
    .code    (del_code),
    .dout    (filt_lvl)
  );

  underlap_split #(.CODE_W(DLY_W)) u_split (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .din     (filt_lvl),
    .code    (dly_code),
    .state   (leg_state)
  );

  drive_gate u_gate (
    .state     (leg_state),
    .inh_n     (inh_n),
    .force_off (force_off),
    .drv_hi    (drv_hi),
    .drv_lo    (drv_lo)
  );
endmodule

// File: rtl/pgc_checker.sv
module pgc_checker (
  input logic clk,
  input logic rst_n,
  input logic tick_en,
  input logic pwm_raw,
  input logic inh_n,
  input logic force_off,
  input logic filt_lvl,
  input logic drv_hi,
  input logic drv_lo
);
  // R5
  no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_hi && drv_lo));

  // R5
  hi_rise_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_hi) |-> $past(!drv_lo));

  // R5
  lo_rise_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_lo) |-> $past(!drv_hi));

  // R6
  filt_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_lvl != $past(filt_lvl)) |-> $past(tick_en));

  // R3
  filt_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_lvl != $past(filt_lvl)) |-> ($past(pwm_raw) == filt_lvl));

  // R7
  inhibit_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inh_n |-> (!drv_hi && !drv_lo));

  // R8
  force_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |-> (!drv_hi && !drv_lo));
endmodule

bind phase_gate_conditioner pgc_checker u_pgc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .pwm_raw   (pwm_raw),
  .inh_n     (inh_n),
  .force_off (force_off),
  .filt_lvl  (filt_lvl),
  .drv_hi    (drv_hi),
  .drv_lo    (drv_lo)
);

// File: tb/tb_phase_gate_conditioner.sv
module tb_phase_gate_conditioner;
  localparam int PERIOD = 10;
  localparam int NV = 10;
  localparam int VD [NV] = '{122, 122, 122, 122, 127, 127, 0,   0,   100, 100};
  localparam int VY [NV] = '{62,  62,  62,  62,  63,  63,  0,   0,   54,  54};
  localparam int VL [NV] = '{6,   5,   6,   5,   1,   3,   128, 127, 40,  27};
  localparam int VP [NV] = '{1,   1,   0,   0,   1,   1,   1,   1,   0,   0};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en;
  logic       pwm_raw;
  logic [6:0] del_code;
  logic [5:0] dly_code;
  logic       inh_n;
  logic       force_off;
  logic       drv_hi;
  logic       drv_lo;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_n = 0;
  int tick_div = 1;

  always #(PERIOD/2) clk = ~clk;

  phase_gate_conditioner dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pwm_raw(pwm_raw),
    .del_code(del_code), .dly_code(dly_code), .inh_n(inh_n),
    .force_off(force_off), .drv_hi(drv_hi), .drv_lo(drv_lo)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #(PERIOD/4);
    cyc_n++;
    tick_en = (tick_div <= 1) || ((cyc_n % tick_div) == 0);
  endtask

  task automatic run_vec(input int dc, input int yc, input int len, input int pol, input string req);
    int pdt, pdy, act_cnt, opp_low, both, act_exp, opp_exp;
    bit pass;
    pdt = 128 - dc;
    pdy = 64 - yc;
    pass = (len >= pdt);
    act_exp = pass ? ((len > pdy) ? len - pdy : 0) : 0;
    opp_exp = pass ? len + pdy : 0;
    del_code = 7'(dc);
    dly_code = 6'(yc);
    pwm_raw = ~pol[0];
    for (int i = 0; i < 200; i++) step();
    act_cnt = 0; opp_low = 0; both = 0;
    pwm_raw = pol[0];
    for (int i = 0; i < len + 200; i++) begin
      step();
      if (i == len - 1) pwm_raw = ~pol[0];
      if ((pol[0] ? drv_hi : drv_lo)) act_cnt++;
      if (!(pol[0] ? drv_lo : drv_hi)) opp_low++;
      if (drv_hi && drv_lo) both++;
    end
    check(act_cnt == act_exp, {req, " active drive high cycles"}, act_cnt, act_exp);
    check(opp_low == opp_exp, {req, " opposite drive low cycles"}, opp_low, opp_exp);
    check(both == 0, "R5 no overlap", both, 0);
  endtask

  initial begin
    #(PERIOD*150000);
    n_bad++;
    $display("FAIL R1 watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int idx;
    rst_n = 1'b0; tick_en = 1'b1; pwm_raw = 1'b0;
    del_code = 7'd122; dly_code = 6'd60;
    inh_n = 1'b1; force_off = 1'b0;
    // R1 reset state
    #(PERIOD*3);
    check(!drv_hi && !drv_lo, "R1 both low in reset", {drv_hi, drv_lo}, 0);
    @(posedge clk); #(PERIOD/4);
    rst_n = 1'b1;
    step(); step(); step();
    check(!drv_lo, "R1 lo still off after 3 ticks", drv_lo, 0);
    step();
    check(drv_lo && !drv_hi, "R1 lo on after pdy=4 ticks", {drv_hi, drv_lo}, 1);

    // R2 R3 R4 R5 table walk
    for (int v = 0; v < NV; v++)
      run_vec(VD[v], VY[v], VL[v], VP[v], VP[v] ? "R3 R2" : "R4 R2");

    // R5 latency: pdt=6, pdy=2
    del_code = 7'd122; dly_code = 6'd62; pwm_raw = 1'b0;
    for (int i = 0; i < 200; i++) step();
    pwm_raw = 1'b1;
    idx = -1;
    begin
      int lo_drop;
      lo_drop = -1;
      for (int i = 0; i < 20; i++) begin
        step();
        if (lo_drop < 0 && !drv_lo) lo_drop = i;
        if (idx < 0 && drv_hi) idx = i;
      end
      check(lo_drop == 5, "R5 lo falls with filtered change", lo_drop, 5);
      check(idx == 7, "R5 hi rise index pdt+pdy-1", idx, 7);
    end

    // R7 inhibit, processing continues
    inh_n = 1'b0; #1;
    check(!drv_hi && !drv_lo, "R7 inhibit clamps", {drv_hi, drv_lo}, 0);
    pwm_raw = 1'b0;
    for (int i = 0; i < 20; i++) step();
    check(!drv_hi && !drv_lo, "R7 still clamped", {drv_hi, drv_lo}, 0);
    inh_n = 1'b1; #1;
    check(drv_lo && !drv_hi, "R7 release shows settled low", {drv_hi, drv_lo}, 1);

    // R8 force-off
    force_off = 1'b1; #1;
    check(!drv_hi && !drv_lo, "R8 force clamps", {drv_hi, drv_lo}, 0);
    for (int i = 0; i < 5; i++) step();
    check(!drv_hi && !drv_lo, "R8 force held", {drv_hi, drv_lo}, 0);
    force_off = 1'b0; #1;
    check(drv_lo && !drv_hi, "R8 release restores", {drv_hi, drv_lo}, 1);

    // R6 ticks every second cycle, pdt=3 ticks, pdy=1 tick
    tick_div = 2;
    del_code = 7'd125; dly_code = 6'd63;
    for (int i = 0; i < 40; i++) step();
    begin
      int hc;
      hc = 0;
      pwm_raw = 1'b1;
      for (int i = 0; i < 40; i++) begin
        step();
        if (i == 3) pwm_raw = 1'b0;
        if (drv_hi) hc++;
      end
      check(hc == 0, "R6 four cycles = two ticks deleted", hc, 0);
      hc = 0;
      pwm_raw = 1'b1;
      for (int i = 0; i < 40; i++) begin
        step();
        if (i == 5) pwm_raw = 1'b0;
        if (drv_hi) hc++;
      end
      check(hc > 0, "R6 six cycles = three ticks passes", hc, 1);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule